// File: doc/BRIEF.md
# Ordered Break Condition Sequencer

This block sits between a set of six break comparators and the halt logic of a processor debug unit. Each comparator delivers a one-cycle match pulse. The block either requests a halt as soon as any comparator fires, or it waits for a chain of comparators to fire in a fixed order before it requests the halt. The block records which comparators have fired. For each chain stage it also keeps a flag that says "this stage has matched and is waiting for its successor". A debugger reads both sets of flags as plain status pins.

Comparators 1 to 4 form the main group. Chains of length 2, 3 or 4 run on this group and always end on comparator 1. Comparators 6 and 5 form a separate two-stage pair. A mode code selects one behaviour at a time. A clear input returns all progress and all flags to zero. When a break request is issued, all progress and all flags are also wiped. There is no streaming data path, so every pin is a plain level or pulse.

Top module: `seqbrk_top`

## Requirements
- R1: After reset, brk_o, hit_o and stage_o are all zero.
- R2: hit_o[i] goes to 1 one cycle after match_i[i] is 1, in every mode. It then stays at 1 until a clear or a break wipes it.
- R3: clear_i wipes hit_o, stage_o and the chain progress at the next edge. In the same cycle it suppresses any break and any match.
- R4: Mode 1 (any) raises brk_o one cycle after any bit of match_i is 1.
- R5: Mode 2 raises brk_o one cycle after condition 1 matches, provided condition 2 matched in an earlier cycle.
- R6: Mode 3 raises brk_o only after conditions 3, 2 and 1 match in that order.
- R7: Mode 4 raises brk_o only after conditions 4, 3, 2 and 1 match in that order.
- R8: Mode 5 raises brk_o one cycle after condition 5 matches, provided condition 6 matched in an earlier cycle. Conditions 1 to 4 play no part in this mode.
- R9: A match on a chain condition that is not yet due is ignored. It does not advance the chain and does not set its stage flag.
- R10: When several conditions match in one cycle, the chain advances by at most one stage.
- R11: stage_o bits 0, 1, 2 and 3 belong to conditions 2, 3, 4 and 6. A bit reads 1 once its condition has matched in its turn and its successor has not yet matched. It also reads 1 when its condition matches again after its successor has matched. When its successor matches, the bit drops to 0.
- R12: brk_o is high for exactly one cycle. All match inputs are ignored in that cycle. hit_o and stage_o read zero while brk_o is high, and they are still zero in the cycle after it.
- R13: Mode codes 0, 6 and 7 never raise brk_o. Only hit_o is updated in these modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode code: 0 off, 1 any, 2/3/4 chain length, 5 pair 6 then 5, 6/7 off |
| clear_i | input | 1 | Wipes all flags and chain progress |
| match_i | input | 6 | Comparator match pulses; bit i is condition i+1 |
| brk_o | output | 1 | One-cycle break request |
| hit_o | output | 6 | Sticky per-condition match flags |
| stage_o | output | 4 | Waiting-stage flags for conditions 2, 3, 4, 6 |

## Verification
Every result is registered once. A match applied in a cycle shows up on hit_o, stage_o and brk_o right after the next rising edge, and the wipe caused by a break shows up at that same edge. The bench changes the inputs just after a falling edge. It compares all three outputs at the following falling edge against a model that advances one step per cycle. Because of this, a result that comes one cycle early or one cycle late is reported as a mismatch.

// File: rtl/seqbrk_pkg.sv
package seqbrk_pkg;

  localparam int NUM_COND  = 6;
  localparam int MAIN_LEN  = 4;
  localparam int PAIR_LEN  = 2;
  localparam int STAGE_W   = (MAIN_LEN - 1) + (PAIR_LEN - 1);

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_ANY   = 3'd1,
    MODE_CH2   = 3'd2,
    MODE_CH3   = 3'd3,
    MODE_CH4   = 3'd4,
    MODE_PAIR  = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } mode_e;

endpackage

// File: rtl/seqbrk_hits.sv
module seqbrk_hits #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         take_i,
  input  logic [N-1:0] match_i,
  output logic [N-1:0] hit_o
);

  logic [N-1:0] hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hit_q <= '0;
    else if (clr_i)  hit_q <= '0;
    else if (take_i) hit_q <= hit_q | match_i;
  end

  assign hit_o = hit_q;

  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((hit_q & $past(hit_q)) == $past(hit_q))); // R2

  AST_HIT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !clr_i) |=> ((hit_q & $past(match_i)) == $past(match_i))); // R2

endmodule

// File: rtl/seqbrk_chain.sv
module seqbrk_chain #(
  parameter int MAXLEN = 4,
  parameter int LW     = $clog2(MAXLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic [LW-1:0]     len_i,
  input  logic [MAXLEN-1:0] cond_i,
  output logic              fire_o,
  output logic [MAXLEN-2:0] flag_o
);

  localparam int PW = $clog2(MAXLEN);

  logic [PW-1:0]     pos_q;
  logic [MAXLEN-2:0] flag_q;
  logic [MAXLEN-2:0] set_v, drop_v;
  logic [LW-1:0]     exp_idx;
  logic              ok, hit_exp, advance;

  // chain runs from cond_i[len-1] down to cond_i[0]
  assign ok      = (len_i >= LW'(2)) && (len_i <= LW'(MAXLEN)) && (LW'(pos_q) < len_i);
  assign exp_idx = len_i - LW'(1) - LW'(pos_q);

  always_comb begin
    hit_exp = 1'b0;
    for (int k = 0; k < MAXLEN; k++) begin
      if (exp_idx == LW'(k)) hit_exp = cond_i[k];
    end
  end

  assign advance = ok && !hold_i && hit_exp;
  assign fire_o  = advance && (exp_idx == '0);

  for (genvar k = 1; k < MAXLEN; k++) begin : g_stage
    assign set_v[k-1]  = ok && !hold_i && cond_i[k] &&
                         (LW'(k) < len_i) && (LW'(k) >= exp_idx);
    assign drop_v[k-1] = advance && (exp_idx == LW'(k - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      flag_q <= '0;
    end else if (clr_i || fire_o) begin
      pos_q  <= '0;
      flag_q <= '0;
    end else begin
      if (advance) pos_q <= pos_q + PW'(1);
      flag_q <= (flag_q | set_v) & ~drop_v;
    end
  end

  assign flag_o = flag_q;

  AST_POS_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + PW'(1) || pos_q == '0)); // R10

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_i) |=> ($stable(pos_q) && $stable(flag_q))); // R12

endmodule

// File: rtl/seqbrk_top.sv
module seqbrk_top
  import seqbrk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode_i,
  input  logic                 clear_i,
  input  logic [NUM_COND-1:0]  match_i,
  output logic                 brk_o,
  output logic [NUM_COND-1:0]  hit_o,
  output logic [STAGE_W-1:0]   stage_o
);

  localparam int MLW = $clog2(MAIN_LEN + 1);
  localparam int PLW = $clog2(PAIR_LEN + 1);

  mode_e             mode;
  logic [MLW-1:0]    len_main;
  logic [PLW-1:0]    len_pair;
  logic              brk_q, brk_d, wipe;
  logic              fire_main, fire_pair, fire_any;
  logic [MAIN_LEN-2:0] flag_main;
  logic [PAIR_LEN-2:0] flag_pair;

  assign mode = mode_e'(mode_i);

  always_comb begin
    len_main = '0;
    len_pair = '0;
    case (mode)
      MODE_CH2:  len_main = MLW'(2);
      MODE_CH3:  len_main = MLW'(3);
      MODE_CH4:  len_main = MLW'(4);
      MODE_PAIR: len_pair = PLW'(2);
      default: ;
    endcase
  end

  assign fire_any = (mode == MODE_ANY) && (|match_i) && !brk_q;
  assign brk_d    = !clear_i && (fire_main || fire_pair || fire_any);
  assign wipe     = clear_i || brk_d;

  seqbrk_chain #(.MAXLEN(MAIN_LEN)) u_main (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (wipe),
    .hold_i (brk_q),
    .len_i  (len_main),
    .cond_i (match_i[MAIN_LEN-1:0]),
    .fire_o (fire_main),
    .flag_o (flag_main)
  );

  seqbrk_chain #(.MAXLEN(PAIR_LEN)) u_pair (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (wipe),
    .hold_i (brk_q),
    .len_i  (len_pair),
    .cond_i (match_i[NUM_COND-1:NUM_COND-PAIR_LEN]),
    .fire_o (fire_pair),
    .flag_o (flag_pair)
  );

  seqbrk_hits #(.N(NUM_COND)) u_hits (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (wipe),
    .take_i  (!brk_q),
    .match_i (match_i),
    .hit_o   (hit_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= brk_d;
  end

  assign brk_o   = brk_q;
  assign stage_o = {flag_pair, flag_main};

  AST_BRK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |=> !brk_o); // R12

  AST_BRK_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |=> (hit_o == '0 && stage_o == '0)); // R12

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!brk_o && hit_o == '0 && stage_o == '0)); // R3

  AST_OFF_NO_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd0 || mode_i == 3'd6 || mode_i == 3'd7) |=> !brk_o); // R13

  AST_PAIR_NO_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd5) |=> (stage_o[2:0] == '0 || $past(stage_o[2:0]) != '0)); // R8

endmodule

// File: tb/seqbrk_top_test.sv
module seqbrk_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic       clear_i = 1'b0;
  logic [5:0] match_i = '0;
  logic       brk_o;
  logic [5:0] hit_o;
  logic [3:0] stage_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit       mbrk;
  bit [5:0] mhit;
  bit [7:0] mfl;
  int       mpos;

  always #10 clk = ~clk;

  seqbrk_top uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .clear_i (clear_i),
    .match_i (match_i),
    .brk_o   (brk_o),
    .hit_o   (hit_o),
    .stage_o (stage_o)
  );

  function automatic string brk_tag(input int md);
    case (md)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic model(input int md, input bit [5:0] m, input bit clr);
    bit       fire;
    bit [7:0] nfl;
    int       npos;
    int       c;
    if (clr) begin
      mbrk = 0; mhit = '0; mfl = '0; mpos = 0;
      return;
    end
    if (mbrk) begin
      mbrk = 0;
      return;
    end
    fire = 0;
    nfl  = mfl;
    npos = mpos;
    mhit = mhit | m;
    if (md == 1 && m != 0) fire = 1;
    if (md >= 2 && md <= 4) begin
      c = md - mpos;
      for (int n = 2; n <= md; n++)
        if (m[n-1] && n >= c) nfl[n] = 1;
      if (m[c-1]) begin
        if (c == 1) fire = 1;
        else begin
          if (c + 1 <= md) nfl[c+1] = 0;
          npos = mpos + 1;
        end
      end
    end
    if (md == 5) begin
      if (!mfl[6]) begin
        if (m[5]) nfl[6] = 1;
      end else if (m[4]) fire = 1;
    end
    if (fire) begin
      mbrk = 1; mhit = '0; mfl = '0; mpos = 0;
    end else begin
      mfl = nfl; mpos = npos;
    end
  endtask

  task automatic compare(input string tag, input int md);
    bit [3:0] est;
    string    bt;
    est = {mfl[6], mfl[4], mfl[3], mfl[2]};
    checks++;
    if (brk_o !== mbrk || hit_o !== mhit || stage_o !== est) begin
      fails++;
      if (brk_o !== mbrk) begin
        bt = (tag != "") ? tag : brk_tag(md);
        $display("FAIL %s brk_o actual=%0b expected=%0b mode=%0d", bt, brk_o, mbrk, md);
      end
      if (hit_o !== mhit)
        $display("FAIL %s hit_o actual=%b expected=%b mode=%0d",
                 (tag != "") ? tag : "R2", hit_o, mhit, md);
      if (stage_o !== est)
        $display("FAIL %s stage_o actual=%b expected=%b mode=%0d",
                 (tag != "") ? tag : "R11", stage_o, est, md);
    end
  endtask

  task automatic step(input int md, input bit [5:0] m, input bit clr, input string tag);
    mode_i  = md[2:0];
    match_i = m;
    clear_i = clr;
    model(md, m, clr);
    @(posedge clk);
    @(negedge clk);
    compare(tag, md);
  endtask

  function automatic bit [5:0] pulse(input int k);
    return (k == 0) ? 6'd0 : (6'd1 << (k - 1));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mbrk = 0; mhit = '0; mfl = '0; mpos = 0;
    @(negedge clk);
    compare("R1", 0);

    // R9: out-of-order matches are ignored, then correct order breaks
    step(3, 6'b000001, 1, "R3");
    step(3, 6'b000001, 0, "R9");
    step(3, 6'b000010, 0, "R9");
    step(3, 6'b000100, 0, "R9");
    step(3, 6'b000001, 0, "R9");
    step(3, 6'b000010, 0, "R9");
    step(3, 6'b000001, 0, "R6");

    // R10: simultaneous matches advance one stage
    step(4, 6'b000000, 1, "R3");
    step(4, 6'b001100, 0, "R10");
    step(4, 6'b000111, 0, "R10");
    step(4, 6'b000011, 0, "R10");
    step(4, 6'b000001, 0, "R7");

    // R11: rematch of a passed stage raises its flag again
    step(3, 6'b000000, 1, "R3");
    step(3, 6'b000100, 0, "R11");
    step(3, 6'b000010, 0, "R11");
    step(3, 6'b000100, 0, "R11");

    // R12: break pulse, matches ignored in the break cycle
    step(2, 6'b000000, 1, "R3");
    step(2, 6'b000010, 0, "R12");
    step(2, 6'b000001, 0, "R12");
    step(2, 6'b000011, 0, "R12");
    step(2, 6'b000000, 0, "R12");

    // R3: clear wins over a completing match
    step(2, 6'b000010, 0, "R5");
    step(2, 6'b000001, 1, "R3");

    // single-pulse sweep over every mode, all sequences of four steps
    for (int md = 0; md < 8; md++) begin
      for (int s = 0; s < 2401; s++) begin
        int v;
        v = s;
        step(md, 6'd0, 1, "R3");
        for (int j = 0; j < 4; j++) begin
          step(md, pulse(v % 7), 0, "");
          v = v / 7;
        end
      end
    end

    // multi-bit sweep for simultaneous matches
    for (int mi = 0; mi < 2; mi++) begin
      int md;
      md = (mi == 0) ? 3 : 5;
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          step(md, 6'd0, 1, "R3");
          step(md, a[5:0], 0, "");
          step(md, b[5:0], 0, "");
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule